// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block is the control front end of a pipelined synchronous SRAM that shares one 32-bit data bus between reads and writes. The bus is split into four 8-bit byte lanes. On every rising clock edge the block samples three chip enables and two address strobes. One strobe belongs to a processor and has priority. The other belongs to a memory controller. Together they decide whether a new access starts, whether the device is deselected, or whether the access already running continues. A started access loads the address register and a two-bit burst sequencer. The sequencer advances in linear or interleaved order.

Write controls work in two ways. A global write writes every lane. Otherwise a byte-write enable together with per-lane selects writes only the chosen lanes. The two strobes use different write timing. A controller-strobe access samples the write controls and data on the same edge that loads the address. A processor-strobe access ignores the write controls on its first edge and decides on the next edge. Read data is held in a register and is driven onto the bus only while output enable is low. The bus is released at once whenever a write is requested, whatever the output enable says.

Top module: `sram_burst_ctrl`

## Requirements
- R1: A processor-strobe access starts on a rising edge when `pstb_n_i` is low and all enables are active (`cs0_n_i` low, `cs1_i` high, `cs2_n_i` low). That edge loads `addr_i` and reads that word, so the word appears on the bus in the next cycle when `oe_n_i` is low.
- R2: While `cs0_n_i` is high, a low `pstb_n_i` starts nothing and writes nothing. Because the processor strobe is low, a low `cstb_n_i` in the same edge is also ignored.
- R3: On the edge that starts a processor-strobe access, the write controls are ignored. On the next edge with no new strobe, the write controls and bus data sampled there write the loaded address.
- R4: A controller-strobe access starts when `cstb_n_i` is low, `pstb_n_i` is high and all enables are active. If the write controls ask for a write on that same edge, the bus data is written to `addr_i` on that edge. If not, the word at `addr_i` is read.
- R5: When `pstb_n_i` and `cstb_n_i` are both low and all enables are active, only the processor-strobe behaviour of R3 applies. Write controls on that edge write nothing.
- R6: When `gw_n_i` is low, all four lanes are written. Otherwise lane k (bits 8k+7:8k, lane 0 lowest) is written only when `bwe_n_i` is low and `lane_n_i[k]` is low. With `bwe_n_i` high and `gw_n_i` high, the access is a read.
- R7: In any cycle where the write controls request a write and the block is selected or is starting a controller-strobe access, the block does not drive `dq_io`, even with `oe_n_i` low.
- R8: Read data is driven on `dq_io` only while `oe_n_i` is low. With `oe_n_i` high the bus is high impedance.
- R9: In a cycle with no new strobe and with `adv_n_i` low, the access uses the next burst address. Only the two low address bits change, and they wrap within the four-word group. With `mode_i` low, the order is start+n mod 4. With `mode_i` high, it is start XOR n.
- R10: A strobe edge where the enables are not all active deselects the block. Later write controls write nothing, and the bus stays high impedance, until a new access starts.
- R11: During reset and after reset the block is deselected and `dq_io` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs0_n_i | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_n_i | input | 1 | Chip enable, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low, higher priority |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | 4 | Per-lane byte-write selects, active low, bit 0 = lowest byte |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Word address |
| dq_io | inout | 32 | Shared read/write data bus |

## Verification
The hardest case to reach is a processor-strobe write. The bus still holds the read data launched by the strobe edge, output enable stays low, and the bench must drive its write data in that same cycle. The stimulus starts the access with the write controls already asserted, which must be ignored. In the next cycle it raises the write controls and drives data, and it expects the bench's own value on `dq_io`. Any drive from the block turns the bus into X and is caught. The same pattern with both strobes low, and with the primary enable high, shows the priority and gating rules through read-back that leaves memory unchanged.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_START = 2'd1,
    ACC_CONT  = 2'd2,
    ACC_DESEL = 2'd3
  } acc_kind_e;

  function automatic logic [1:0] burst_low(input logic [1:0] start, input logic [1:0] step,
                                           input logic interleave);
    burst_low = interleave ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode #(
  parameter int LANES = 4
) (
  input  logic             sel_i,
  input  logic             cs0_n_i,
  input  logic             cs1_i,
  input  logic             cs2_n_i,
  input  logic             pstb_n_i,
  input  logic             cstb_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_n_i,
  output logic             p_start_o,
  output logic             c_start_o,
  output logic             desel_o,
  output logic             cont_o,
  output logic             wr_req_o,
  output logic [LANES-1:0] wr_lanes_o
);
  logic en_all, p_seen, c_seen, wr_any, wr_window;
  logic [LANES-1:0] raw_lanes;

  assign en_all = ~cs0_n_i & cs1_i & ~cs2_n_i;
  // processor strobe only counts with primary enable low
  assign p_seen = ~pstb_n_i & ~cs0_n_i;
  // controller strobe masked by any low processor strobe
  assign c_seen = ~cstb_n_i & pstb_n_i;

  assign p_start_o = p_seen & en_all;
  assign c_start_o = c_seen & en_all;
  assign desel_o   = (p_seen | c_seen) & ~en_all;
  assign cont_o    = sel_i & ~p_seen & ~c_seen & pstb_n_i;

  assign raw_lanes = ~gw_n_i ? {LANES{1'b1}} : (~bwe_n_i ? ~lane_n_i : '0);
  assign wr_any    = |raw_lanes;
  assign wr_window = c_start_o | cont_o;
  assign wr_req_o  = wr_any & (wr_window | (sel_i & ~p_start_o & ~desel_o));
  assign wr_lanes_o = wr_window ? raw_lanes : '0;
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BW = 2;

  logic [ADDR_W-1:BW] base_q;
  logic [BW-1:0]      start_q, cnt_q, step;

  assign step       = adv_i ? cnt_q + 2'd1 : cnt_q;
  assign addr_o     = {base_q, burst_low(start_q, cnt_q, mode_i)};
  assign acc_addr_o = load_i ? addr_i : {base_q, burst_low(start_q, step, mode_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      base_q  <= addr_i[ADDR_W-1:BW];
      start_q <= addr_i[BW-1:0];
      cnt_q   <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  // R1
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));

  // R9
  lin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !mode_i && $stable(mode_i)) |=>
      (addr_o[BW-1:0] == $past(addr_o[BW-1:0]) + 2'd1) &&
      (addr_o[ADDR_W-1:BW] == $past(addr_o[ADDR_W-1:BW])));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_go_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              oe_n_i,
  input  logic              wr_req_i,
  output logic              drive_o,
  output logic [DATA_W-1:0] dq_o
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= rd_go_i;
      if (rd_go_i) data_q <= rd_data_i;
    end
  end

  assign drive_o = vld_q & ~oe_n_i & ~wr_req_i;
  assign dq_o    = data_q;

  // R11
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !vld_q);
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs0_n_i,
  input  logic              cs1_i,
  input  logic              cs2_n_i,
  input  logic              pstb_n_i,
  input  logic              cstb_n_i,
  input  logic              adv_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [3:0]        lane_n_i,
  input  logic              mode_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  inout  wire  [31:0]       dq_io
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel_q;
  logic              p_start, c_start, desel, cont, wr_req, load, rd_go, drive;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] acc_addr, cur_addr;
  logic [DATA_W-1:0] rd_data, dq_out;

  sram_strobe_decode #(.LANES(LANES)) u_dec (
    .sel_i(sel_q), .cs0_n_i(cs0_n_i), .cs1_i(cs1_i), .cs2_n_i(cs2_n_i),
    .pstb_n_i(pstb_n_i), .cstb_n_i(cstb_n_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i),
    .lane_n_i(lane_n_i[LANES-1:0]), .p_start_o(p_start), .c_start_o(c_start),
    .desel_o(desel), .cont_o(cont), .wr_req_o(wr_req), .wr_lanes_o(wr_lanes)
  );

  assign load = p_start | c_start;

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .adv_i(cont & ~adv_n_i),
    .mode_i(mode_i), .addr_i(addr_i), .acc_addr_o(acc_addr), .addr_o(cur_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i(clk_i), .we_i(wr_lanes), .addr_i(acc_addr), .wdata_i(dq_io[DATA_W-1:0]),
    .rdata_o(rd_data)
  );

  assign rd_go = p_start | ((c_start | cont) & ~(|wr_lanes));

  sram_bus_ctrl #(.DATA_W(DATA_W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_go_i(rd_go), .rd_data_i(rd_data),
    .oe_n_i(oe_n_i), .wr_req_i(wr_req), .drive_o(drive), .dq_o(dq_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= 1'b0;
    else if (load)  sel_q <= 1'b1;
    else if (desel) sel_q <= 1'b0;
  end

  assign dq_io = drive ? dq_out : 'z;

  // R7
  wr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_lanes) |-> !drive);

  // R3
  p_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_start |-> (wr_lanes == '0));

  // R6
  gw_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_start && !gw_n_i) |-> (wr_lanes == {LANES{1'b1}}));

  // R10
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && !c_start) |-> (wr_lanes == '0));

  // R2
  cs0_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs0_n_i && !pstb_n_i) |-> !load);
endmodule

// File: tb/sim_sram_burst_ctrl.sv
module sim_sram_burst_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs0_n, cs1, cs2_n, pstb_n, cstb_n, adv_n, gw_n, bwe_n, mode, oe_n;
  logic [3:0]  lane_n;
  logic [5:0]  addr;
  logic        tb_drv;
  logic [31:0] tb_dq;
  wire  [31:0] dq;
  int cyc = 0, vecs = 0, errs = 0;
  bit done = 0;
  logic [31:0] ref_mem [64];

  int st_q[$];
  int kd_q[$];
  logic [31:0] vl_q[$];
  string rq_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign dq = tb_drv ? tb_dq : 'z;

  sram_burst_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs0_n_i(cs0_n), .cs1_i(cs1), .cs2_n_i(cs2_n),
    .pstb_n_i(pstb_n), .cstb_n_i(cstb_n), .adv_n_i(adv_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .lane_n_i(lane_n), .mode_i(mode), .oe_n_i(oe_n),
    .addr_i(addr), .dq_io(dq)
  );

  // monitor: pops the expectation stamped for this cycle
  always @(negedge clk) begin
    if (st_q.size() > 0 && st_q[0] == cyc) begin
      int k;
      logic [31:0] v;
      string r;
      k = kd_q.pop_front(); v = vl_q.pop_front(); r = rq_q.pop_front();
      void'(st_q.pop_front());
      vecs++;
      if (k == 0) begin
        if (dq !== 32'hzzzz_zzzz) begin
          errs++; $display("FAIL %s: dq=%h expected=zzzzzzzz", r, dq);
        end
      end else if (dq !== v) begin
        errs++; $display("FAIL %s: dq=%h expected=%h", r, dq, v);
      end
    end
  end

  task automatic expect_z(input string r);
    st_q.push_back(cyc); kd_q.push_back(0); vl_q.push_back('0); rq_q.push_back(r);
  endtask
  task automatic expect_v(input logic [31:0] v, input string r);
    st_q.push_back(cyc); kd_q.push_back(1); vl_q.push_back(v); rq_q.push_back(r);
  endtask

  task automatic nxt();
    @(posedge clk); #1;
    cs0_n = 1; cs1 = 0; cs2_n = 1; pstb_n = 1; cstb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; lane_n = 4'hF; oe_n = 0; tb_drv = 0; tb_dq = '0;
  endtask
  task automatic en();
    cs0_n = 0; cs1 = 1; cs2_n = 0;
  endtask
  task automatic desel();
    nxt(); cstb_n = 0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                         input logic g, input logic b, input logic [3:0] ln);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++)
      if (!g || (!b && !ln[k])) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic cwrite(input logic [5:0] a, input logic [31:0] d, input logic g,
                        input logic b, input logic [3:0] ln, input string r);
    nxt(); en(); cstb_n = 0; addr = a; gw_n = g; bwe_n = b; lane_n = ln;
    tb_drv = 1; tb_dq = d;
    if (!g || (!b && ln != 4'hF)) begin
      expect_v(d, r);
      ref_mem[a] = merge(ref_mem[a], d, g, b, ln);
    end
    desel();
  endtask

  task automatic pread(input logic [5:0] a, input string r);
    nxt(); en(); pstb_n = 0; addr = a;
    nxt(); expect_v(ref_mem[a], r);
    desel();
  endtask

  task automatic wburst(input logic [5:0] a, input logic [31:0] d0, input string r);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] lo;
      nxt();
      lo = mode ? (a[1:0] ^ 2'(i)) : (a[1:0] + 2'(i));
      if (i == 0) begin en(); cstb_n = 0; addr = a; end
      else adv_n = 0;
      gw_n = 0; tb_drv = 1; tb_dq = d0 + 32'(i);
      expect_v(d0 + 32'(i), r);
      ref_mem[{a[5:2], lo}] = d0 + 32'(i);
    end
    desel();
  endtask

  task automatic rburst(input logic [5:0] a, input string r);
    nxt(); en(); pstb_n = 0; addr = a;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] lo;
      nxt();
      lo = mode ? (a[1:0] ^ 2'(i)) : (a[1:0] + 2'(i));
      if (i < 3) adv_n = 0;
      expect_v(ref_mem[{a[5:2], lo}], r);
    end
    desel();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    mode = 0; addr = '0;
    cs0_n = 1; cs1 = 0; cs2_n = 1; pstb_n = 1; cstb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; lane_n = 4'hF; oe_n = 0; tb_drv = 0; tb_dq = '0;
    @(posedge clk); #1;
    expect_z("R11 in reset");
    @(posedge clk); #1; rst_n = 1;
    nxt(); expect_z("R11 after reset");

    // R4 controller-strobe full write, then R1 read back
    cwrite(6'd4, 32'hA5A5_1234, 0, 1, 4'hF, "R4 write same edge");
    pread(6'd4, "R1 read after R4 write");
    cwrite(6'd5, 32'h0BAD_F00D, 0, 1, 4'hF, "R4 second word");
    pread(6'd5, "R1 second word");

    // R3 processor-strobe write: first-edge controls ignored, next edge writes
    nxt(); en(); pstb_n = 0; addr = 6'd5; gw_n = 0; tb_drv = 1; tb_dq = 32'hDEAD_DEAD;
    nxt(); expect_v(32'h0BAD_F00D, "R3 first-edge write ignored");
    desel();
    nxt(); en(); pstb_n = 0; addr = 6'd7;
    nxt(); gw_n = 0; tb_drv = 1; tb_dq = 32'h7777_0007;
    expect_v(32'h7777_0007, "R7 released during write with oe low");
    ref_mem[7] = 32'h7777_0007;
    desel();
    pread(6'd7, "R3 second-edge write");

    // R6 byte lanes
    cwrite(6'd4, 32'h1122_3344, 1, 0, 4'b1010, "R6 lanes 0 and 2");
    pread(6'd4, "R6 merged word");
    cwrite(6'd4, 32'hFFFF_FFFF, 1, 1, 4'b0000, "R6 selects without enable");
    pread(6'd4, "R6 no write without byte enable");
    cwrite(6'd5, 32'h00EE_0000, 1, 0, 4'b1011, "R6 lane 2 only");
    pread(6'd5, "R6 lane 2 only");

    // R5 priority
    nxt(); en(); pstb_n = 0; cstb_n = 0; addr = 6'd7; gw_n = 0; tb_drv = 1;
    tb_dq = 32'h5555_5555;
    nxt(); expect_v(ref_mem[7], "R5 controller strobe masked");
    desel();
    pread(6'd7, "R5 memory unchanged");

    // R2 primary enable gates processor strobe
    nxt(); cs0_n = 1; cs1 = 1; cs2_n = 0; pstb_n = 0; cstb_n = 0; addr = 6'd7;
    gw_n = 0; tb_drv = 1; tb_dq = 32'h2222_2222;
    nxt(); expect_z("R2 no access started");
    pread(6'd7, "R2 memory unchanged");

    // R10 deselect then write controls
    nxt(); en(); pstb_n = 0; addr = 6'd4;
    nxt(); cstb_n = 0; cs0_n = 0; cs1 = 0; cs2_n = 0;
    nxt(); expect_z("R10 bus idle after deselect");
    nxt(); gw_n = 0; tb_drv = 1; tb_dq = 32'h9999_9999; addr = 6'd4;
    pread(6'd4, "R10 write ignored after deselect");

    // R8 output enable high
    nxt(); en(); pstb_n = 0; addr = 6'd4;
    nxt(); oe_n = 1; expect_z("R8 oe high");
    nxt(); expect_v(ref_mem[4], "R8 oe low again");
    desel();

    // R9 linear and interleaved bursts
    mode = 0;
    wburst(6'd6, 32'hC000_0000, "R9 linear write burst");
    rburst(6'd6, "R9 linear read burst");
    pread(6'd4, "R9 linear wrap to low 0");
    mode = 1;
    wburst(6'd9, 32'hE000_0000, "R9 interleaved write burst");
    rburst(6'd9, "R9 interleaved read burst");
    pread(6'd11, "R9 interleaved third word");

    nxt(); nxt();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule